// File: doc/BRIEF.md
# HDLC Receive Frame Length Supervisor

This block sits beside an HDLC receive deframer and watches the stream of received bytes. It counts the bytes of each frame and, when length checking is enabled, stops reception as soon as a frame grows past a programmable maximum of (L + 1) × 32 bytes, where L is a 7-bit length code. The allowed range is therefore 32 to 4096 bytes.

An overlong frame is reported in the same way as an abort sent by the far end. The block pulses a message-end interrupt, raises an aborted status bit, and asserts a discard signal so that the storage path drops the rest of the frame. Software tells the two cases apart by the byte count. After a length overflow the count rests one or two bytes above the programmed maximum. After a genuine abort it is at or below the maximum.

Flag detection, CRC checking, FIFO storage and register access lie outside this block. It only counts, compares and reports.

Top module: `rx_len_guard`

## Requirements
- R1: After reset, the byte count is 0 and the message-end pulse, the aborted bit and discard are all 0.
- R2: A frame-start strobe clears the byte count to 0 on the next edge and clears aborted and discard. A byte strobe in the same cycle is not counted.
- R3: Inside a frame, each byte-valid strobe raises the byte count by one on the following edge.
- R4: The limit is (L + 1) × 32 bytes. With checking enabled, the byte strobe that takes the count to limit + 1 makes message-end pulse, aborted go to 1 and discard go to 1, all on that same edge.
- R5: After a length overflow the count advances by at most one more byte, to limit + 2, and then holds. Discard stays at 1 until the next frame start. Later frame-end or abort inputs produce no message-end pulse.
- R6: A genuine abort inside a frame pulses message-end and sets aborted to 1. The count is left where it was, and discard stays 0.
- R7: A frame that ends normally at or below the limit pulses message-end with aborted at 0.
- R8: With checking disabled, no length abort occurs. The count goes on past the limit and saturates at 8191, which is all ones in 13 bits.
- R9: The enable bit and the length code are sampled at frame start. Changing them in the middle of a frame has no effect on that frame.
- R10: The overflow check takes priority over a frame end in the same cycle. Byte, end and abort inputs that arrive outside a frame are ignored.
- R11: Message-end is a single-cycle pulse, and it fires at most once per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld_i | input | 1 | One received byte is delivered this cycle |
| frm_start_i | input | 1 | Opening flag of a new frame |
| frm_end_i | input | 1 | Closing flag of the current frame |
| line_abort_i | input | 1 | An abort sequence was received from the line |
| chk_en_i | input | 1 | Length checking enable, sampled at frame start |
| len_code_i | input | 7 | Length code L, sampled at frame start |
| byte_cnt_o | output | 13 | Byte count of the current or last frame |
| msg_end_o | output | 1 | Message-end interrupt pulse |
| aborted_o | output | 1 | The last frame ended by abort or length overflow |
| discard_o | output | 1 | Drop further bytes of the current frame |

## Verification
The bench builds the block with its default parameters: a 7-bit length code and 32-byte blocks. With these values the whole programmable range, from 32 to 4096 bytes, can be reached, and so can the 13-bit saturation point at 8191. Table frames use length codes 0, 1, 2 and 127. These place the limit edge at exactly limit, limit + 1, limit + 2 and beyond, so both the one-byte and the two-byte overflow counts appear. A frame of 8195 bytes with checking disabled reaches counter saturation.

// File: rtl/rx_len_pkg.sv
package rx_len_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_OVER = 2'd2
  } rxl_state_e;

  // Limit in bytes: (code + 1) blocks, block size a power of two.
  function automatic int unsigned rxl_limit(input int unsigned code,
                                            input int unsigned blk_bytes);
    return (code + 1) * blk_bytes;
  endfunction

endpackage

// File: rtl/rxl_cfg_latch.sv
module rxl_cfg_latch #(
  parameter int CODE_W      = 7,
  parameter int BLOCK_BYTES = 32,
  parameter int CNT_W       = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              en_q_o,
  output logic [CNT_W-1:0]  limit_o,
  output logic [CNT_W-1:0]  limit_p1_o
);
  import rx_len_pkg::*;

  logic             en_q, en_n;
  logic [CNT_W-1:0] limit_q, limit_n;

  // R9: configuration only moves on a frame start
  always_comb begin
    en_n    = en_q;
    limit_n = limit_q;
    if (load_i) begin
      en_n    = en_i;
      limit_n = CNT_W'(rxl_limit(32'(code_i), BLOCK_BYTES));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      limit_q <= '0;
    end else if (load_i) begin
      en_q    <= en_n;
      limit_q <= limit_n;
    end
  end

  assign en_q_o     = en_q;
  assign limit_o    = limit_q;
  assign limit_p1_o = limit_q + CNT_W'(1);

endmodule

// File: rtl/rxl_byte_counter.sv
module rxl_byte_counter #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_we;

  always_comb begin
    cnt_we = clr_i | inc_i;
    cnt_n  = clr_i ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_n;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/rxl_frame_ctrl.sv
module rxl_frame_ctrl #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             end_i,
  input  logic             abort_i,
  input  logic             byte_i,
  input  logic             en_q_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic [CNT_W-1:0] limit_p1_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             cnt_clr_o,
  output logic             cnt_inc_o,
  output logic             msg_end_o,
  output logic             aborted_o,
  output logic             discard_o
);
  import rx_len_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  rxl_state_e st_q, st_n;
  logic       msg_q, msg_n;
  logic       ab_q, ab_n;

  always_comb begin
    st_n      = st_q;
    msg_n     = 1'b0;
    ab_n      = ab_q;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    if (start_i) begin
      // R2: new frame, bytes in this cycle are not counted
      st_n      = ST_RUN;
      ab_n      = 1'b0;
      cnt_clr_o = 1'b1;
    end else begin
      case (st_q)
        ST_RUN: begin
          // R3/R8: count, saturating at all ones
          cnt_inc_o = byte_i && (cnt_i != CNT_MAX);
          if (byte_i && en_q_i && (cnt_i == limit_i)) begin
            // R4/R10: overflow wins over a same-cycle end
            st_n  = ST_OVER;
            msg_n = 1'b1;
            ab_n  = 1'b1;
          end else if (abort_i) begin
            st_n  = ST_IDLE;   // R6
            msg_n = 1'b1;
            ab_n  = 1'b1;
          end else if (end_i) begin
            st_n  = ST_IDLE;   // R7
            msg_n = 1'b1;
            ab_n  = 1'b0;
          end
        end
        ST_OVER: begin
          // R5: one grace byte, then the count freezes
          cnt_inc_o = byte_i && (cnt_i == limit_p1_i);
        end
        default: begin
          // R10: idle ignores everything but a start
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      msg_q <= 1'b0;
      ab_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      msg_q <= msg_n;
      ab_q  <= ab_n;
    end
  end

  assign msg_end_o = msg_q;
  assign aborted_o = ab_q;
  assign discard_o = (st_q == ST_OVER);

endmodule

// File: rtl/rx_len_guard.sv
module rx_len_guard #(
  parameter int CODE_W      = 7,
  parameter int BLOCK_BYTES = 32,
  localparam int CNT_W      = $clog2(((1 << CODE_W) * BLOCK_BYTES) + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld_i,
  input  logic              frm_start_i,
  input  logic              frm_end_i,
  input  logic              line_abort_i,
  input  logic              chk_en_i,
  input  logic [CODE_W-1:0] len_code_i,
  output logic [CNT_W-1:0]  byte_cnt_o,
  output logic              msg_end_o,
  output logic              aborted_o,
  output logic              discard_o
);

  logic             en_q;
  logic [CNT_W-1:0] limit, limit_p1, cnt;
  logic             cnt_clr, cnt_inc;

  rxl_cfg_latch #(
    .CODE_W      (CODE_W),
    .BLOCK_BYTES (BLOCK_BYTES),
    .CNT_W       (CNT_W)
  ) i_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (frm_start_i),
    .en_i       (chk_en_i),
    .code_i     (len_code_i),
    .en_q_o     (en_q),
    .limit_o    (limit),
    .limit_p1_o (limit_p1)
  );

  rxl_byte_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (cnt_clr),
    .inc_i (cnt_inc),
    .cnt_o (cnt)
  );

  rxl_frame_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (frm_start_i),
    .end_i      (frm_end_i),
    .abort_i    (line_abort_i),
    .byte_i     (byte_vld_i),
    .en_q_i     (en_q),
    .limit_i    (limit),
    .limit_p1_i (limit_p1),
    .cnt_i      (cnt),
    .cnt_clr_o  (cnt_clr),
    .cnt_inc_o  (cnt_inc),
    .msg_end_o  (msg_end_o),
    .aborted_o  (aborted_o),
    .discard_o  (discard_o)
  );

  assign byte_cnt_o = cnt;

endmodule

// File: rtl/rxl_checker.sv
module rxl_checker #(
  parameter int CNT_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_start,
  input logic             byte_vld,
  input logic [CNT_W-1:0] byte_cnt,
  input logic             msg_end,
  input logic             aborted,
  input logic             discard
);

  assert_msg_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_end |=> !msg_end);

  assert_overflow_report_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(discard) |-> (msg_end && aborted));

  assert_start_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |=> (byte_cnt == '0 && !discard && !aborted));

  assert_discard_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (discard && !frm_start) |=> discard);

  assert_frozen_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (discard && !frm_start && !byte_vld) |=> $stable(byte_cnt));

  assert_discard_aborted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    discard |-> aborted);

endmodule

bind rx_len_guard rxl_checker #(.CNT_W(CNT_W)) i_rxl_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .frm_start (frm_start_i),
  .byte_vld  (byte_vld_i),
  .byte_cnt  (byte_cnt_o),
  .msg_end   (msg_end_o),
  .aborted   (aborted_o),
  .discard   (discard_o)
);

// File: tb/test_rx_len_guard.sv
module test_rx_len_guard;

  logic        clk;
  logic        rst_n;
  logic        byte_vld, frm_start, frm_end, line_abort, chk_en;
  logic [6:0]  len_code;
  logic [12:0] byte_cnt;
  logic        msg_end, aborted, discard;

  int compared   = 0;
  int mismatched = 0;
  int pulses     = 0;
  int cycles     = 0;

  rx_len_guard i_rx_len_guard (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_vld_i   (byte_vld),
    .frm_start_i  (frm_start),
    .frm_end_i    (frm_end),
    .line_abort_i (line_abort),
    .chk_en_i     (chk_en),
    .len_code_i   (len_code),
    .byte_cnt_o   (byte_cnt),
    .msg_end_o    (msg_end),
    .aborted_o    (aborted),
    .discard_o    (discard)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) if (rst_n && msg_end) pulses++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    byte_vld = 0; frm_start = 0; frm_end = 0; line_abort = 0;
  endtask

  task automatic open_frame(input bit en, input logic [6:0] code);
    @(negedge clk);
    chk_en = en; len_code = code; frm_start = 1;
    @(negedge clk);
    frm_start = 0;
  endtask

  task automatic send_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      byte_vld = 1;
      @(negedge clk);
    end
    byte_vld = 0;
  endtask

  task automatic close_frame(input bit ab);
    if (ab) line_abort = 1; else frm_end = 1;
    @(negedge clk);
    line_abort = 0; frm_end = 0;
    @(negedge clk);
  endtask

  // {en, code[7], nbytes[13], abort, exp_cnt[13], exp_aborted, exp_discard}
  localparam logic [36:0] VEC [0:9] = '{
    {1'b1, 7'd0,   13'd10, 1'b0, 13'd10, 1'b0, 1'b0},  // R7 short frame
    {1'b1, 7'd0,   13'd32, 1'b0, 13'd32, 1'b0, 1'b0},  // R7 exactly at limit
    {1'b1, 7'd0,   13'd33, 1'b0, 13'd33, 1'b1, 1'b1},  // R4 one over
    {1'b1, 7'd0,   13'd34, 1'b0, 13'd34, 1'b1, 1'b1},  // R5 grace byte
    {1'b1, 7'd0,   13'd40, 1'b0, 13'd34, 1'b1, 1'b1},  // R5 frozen
    {1'b0, 7'd0,   13'd40, 1'b0, 13'd40, 1'b0, 1'b0},  // R8 disabled
    {1'b1, 7'd1,   13'd64, 1'b1, 13'd64, 1'b1, 1'b0},  // R6 abort at limit
    {1'b1, 7'd2,   13'd97, 1'b0, 13'd97, 1'b1, 1'b1},  // R4 limit 96
    {1'b1, 7'd2,   13'd20, 1'b1, 13'd20, 1'b1, 1'b0},  // R6 short abort
    {1'b1, 7'd127, 13'd100,1'b0, 13'd100,1'b0, 1'b0}   // R3 max code
  };

  initial begin
    int p0;
    idle_inputs();
    chk_en = 0; len_code = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", int'(byte_cnt), 0);
    chk("R1 msg_end", int'(msg_end), 0);
    chk("R1 aborted", int'(aborted), 0);
    chk("R1 discard", int'(discard), 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < 10; v++) begin
      logic [36:0] e;
      e  = VEC[v];
      p0 = pulses;
      open_frame(e[36], e[35:29]);
      send_bytes(int'(e[28:16]));
      close_frame(e[15]);
      chk("R3/R4/R5 count", int'(byte_cnt), int'(e[14:2]));
      chk("R4/R6/R7 aborted", int'(aborted), int'(e[1]));
      chk("R4/R5 discard", int'(discard), int'(e[0]));
      chk("R11 one pulse", pulses - p0, 1);
    end

    // R4 / R10 exact overflow edge, same-cycle end
    p0 = pulses;
    open_frame(1, 7'd0);
    chk("R2 cleared", int'(byte_cnt), 0);
    send_bytes(32);
    chk("R3 count at limit", int'(byte_cnt), 32);
    chk("R4 no discard at limit", int'(discard), 0);
    byte_vld = 1; frm_end = 1;
    @(negedge clk);
    frm_end = 0;
    chk("R4 count", int'(byte_cnt), 33);
    chk("R4 msg_end", int'(msg_end), 1);
    chk("R10 aborted wins", int'(aborted), 1);
    chk("R4 discard", int'(discard), 1);
    @(negedge clk);
    chk("R11 pulse ends", int'(msg_end), 0);
    chk("R5 grace", int'(byte_cnt), 34);
    send_bytes(3);
    close_frame(1);
    close_frame(0);
    chk("R5 frozen", int'(byte_cnt), 34);
    chk("R5 discard held", int'(discard), 1);
    chk("R5 no extra pulse", pulses - p0, 1);

    // R2 start clears status
    @(negedge clk); frm_start = 1; byte_vld = 1;
    @(negedge clk); frm_start = 0; byte_vld = 0;
    chk("R2 count", int'(byte_cnt), 0);
    chk("R2 aborted", int'(aborted), 0);
    chk("R2 discard", int'(discard), 0);
    close_frame(0);

    // R9 mid-frame config change ignored
    open_frame(1, 7'd0);
    chk_en = 0; len_code = 7'd127;
    send_bytes(40);
    close_frame(0);
    chk("R9 enable held", int'(byte_cnt), 34);
    chk("R9 aborted", int'(aborted), 1);
    open_frame(0, 7'd0);
    chk_en = 1; len_code = 7'd0;
    send_bytes(40);
    close_frame(0);
    chk("R9 disable held", int'(byte_cnt), 40);
    chk("R9 not aborted", int'(aborted), 0);

    // R10 inputs outside a frame ignored
    p0 = pulses;
    send_bytes(5);
    close_frame(0);
    close_frame(1);
    chk("R10 count held", int'(byte_cnt), 40);
    chk("R10 no pulse", pulses - p0, 0);
    chk("R10 aborted", int'(aborted), 0);

    // R8 saturation with checking off
    open_frame(0, 7'd0);
    send_bytes(8195);
    close_frame(0);
    chk("R8 saturate", int'(byte_cnt), 8191);
    chk("R8 no abort", int'(aborted), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule